// File: doc/BRIEF.md
# Manchester Decoder with Regenerated Bit Clock

This block turns a serial Manchester stream, arriving as a true/complement pair of logic lines, into NRZ data plus a regenerated bit clock that gives exactly one rising edge per received bit. A downstream word-framing block can count those edges to find the word length. A transmission-envelope output stays high for as long as a word is in flight. A second true/complement pair carries self-test traffic, and a select input swaps it in for the live pair so that built-in test can run the same decode path. Parity, framing and capture of short status messages happen elsewhere.

The block runs from a sample clock at `SPB` samples per bit (16 by default). Both lines of the selected pair pass through a two-stage synchroniser. A single gap counter then measures the time since the last accepted mid-bit transition. Transitions that come too early are bit-boundary transitions and are ignored. A long silence ends the word. Word length is unbounded. An active-low master reset aborts any word in progress and returns every output to rest.

Top module: `mrx_decoder`

## Requirements
- R1: Line code: a rising mid-bit transition on the true line encodes 1 and a falling one encodes 0. The true line rests low. The first transition after rest is taken as the mid-bit transition of the first bit, so every word opens with a 1.
- R2: A line level first sampled at clock edge k reaches the outputs at edge k+2. On each accepted mid-bit transition, `dataOut` takes the decoded bit value in that cycle.
- R3: With the default SPB of 16, a transition that arrives 12 or more sample clocks after the previous accepted one is a mid-bit transition. A transition that arrives earlier is a boundary transition and leaves every output unchanged.
- R4: `clkOut` falls in the cycle `dataOut` updates and rises exactly 8 clocks later (SPB/2). This gives one rising edge per decoded bit, with `dataOut` stable across that edge. `clkOut` rests high.
- R5: `envelope` rises in the same cycle that the first bit of a word appears on `dataOut`.
- R6: If 24 clocks (1.5 bits) pass without an accepted transition, `envelope` falls in that 24th cycle. A transition arriving exactly at the 24th clock is still accepted as a bit and keeps the word open. A transition after the word has ended opens a new word.
- R7: Words of any length decode correctly; 1, 4, 35 and 300 bits are exercised.
- R8: `pairErr` is high whenever the true and complement lines of the selected pair carry the same level, with the same two-clock latency as R2.
- R9: With `selTest` high, the self-test pair is decoded and the receive pair has no effect on any output. With `selTest` low, the roles reverse.
- R10: `rstN` low immediately forces `dataOut`=0, `clkOut`=1, `envelope`=0 and `pairErr`=0, and abandons any word in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, SPB cycles per bit |
| rstN | input | 1 | Active-low master reset, asynchronous assert |
| lineP | input | 1 | Receive pair, true line |
| lineN | input | 1 | Receive pair, complement line |
| testP | input | 1 | Self-test pair, true line |
| testN | input | 1 | Self-test pair, complement line |
| selTest | input | 1 | 1 selects the self-test pair, 0 the receive pair |
| dataOut | output | 1 | Reconstructed NRZ data |
| clkOut | output | 1 | Regenerated bit clock, one rising edge per bit |
| envelope | output | 1 | High while a word is being received |
| pairErr | output | 1 | Selected pair true and complement agree |

## Verification
End-of-word detection and acceptance of a new bit compete for the same cycle when a mid-bit transition lands exactly 24 clocks after the previous one. The bench builds two-bit sequences with mid-bit spacings of 24 and 25 clocks. It judges them by how many times `envelope` falls: once for the 24-clock spacing, where the bit wins and the word stays open, and twice for the 25-clock spacing, where the word closes and a new one reopens one cycle later. In both cases exactly two clock edges must be produced. A cycle-by-cycle reference model compares all four outputs throughout the run.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  // Strobes from the control FSM to the datapath, valid for one cycle.
  typedef struct packed {
    logic bitStrobe;  // accepted mid-bit transition: emit a bit
    logic bitVal;     // value of that bit
    logic wordEnd;    // silence limit reached: close the word
  } mrx_ctl_t;

endpackage

// File: rtl/mrx_datapath.sv
module mrx_datapath
  import mrx_pkg::*;
#(
  parameter int SPB         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineP,
  input  logic     lineN,
  input  logic     testP,
  input  logic     testN,
  input  logic     selTest,
  input  mrx_ctl_t ctl,
  output logic     edgeSeen,
  output logic     edgeRise,
  output logic     dataOut,
  output logic     clkOut,
  output logic     envelope,
  output logic     pairErr
);

  localparam int HALF = SPB / 2;
  localparam int LW   = $clog2(HALF + 1);

  // lane 0 = true line, lane 1 = complement line
  logic [1:0] pick;
  logic [1:0] tapNew;
  logic [1:0] tapOld;

  assign pick = selTest ? {testN, testP} : {lineN, lineP};

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic [SYNC_STAGES:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {(SYNC_STAGES + 1){ln == 1}};
      else       chain <= {chain[SYNC_STAGES-1:0], pick[ln]};
    end
    assign tapNew[ln] = chain[SYNC_STAGES-1];
    assign tapOld[ln] = chain[SYNC_STAGES];
  end

  assign edgeSeen = tapNew[0] ^ tapOld[0];
  assign edgeRise = tapNew[0];

  logic [LW-1:0] lowLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= 1'b0;
      clkOut   <= 1'b1;
      lowLeft  <= '0;
      envelope <= 1'b0;
      pairErr  <= 1'b0;
    end else begin
      pairErr <= (tapNew[0] == tapNew[1]);
      if (ctl.bitStrobe) begin
        dataOut <= ctl.bitVal;
        clkOut  <= 1'b0;
        lowLeft <= LW'(HALF - 1);
      end else if (!clkOut) begin
        if (lowLeft == '0) clkOut <= 1'b1;
        else               lowLeft <= lowLeft - LW'(1);
      end
      if (ctl.bitStrobe)    envelope <= 1'b1;
      else if (ctl.wordEnd) envelope <= 1'b0;
    end
  end

  // R4: the clock stays low for more than one cycle after it falls
  a_r4_low_holds: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkOut) |=> !clkOut) else $error("clkOut low pulse too short");

  // R4: data does not move on the rising clock edge
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOut) |-> $stable(dataOut)) else $error("dataOut moved on clkOut rise");

  // R5: envelope opens together with the first bit clock
  a_r5_env_first_bit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(envelope) |-> $fell(clkOut)) else $error("envelope rose without a bit");

  // R6: no clock activity outside a word
  a_r6_idle_clock_high: assert property (@(posedge clk) disable iff (!rstN)
    !envelope |-> clkOut) else $error("clkOut low while idle");

endmodule

// File: rtl/mrx_control.sv
module mrx_control
  import mrx_pkg::*;
#(
  parameter int SPB = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     edgeSeen,
  input  logic     edgeRise,
  output mrx_ctl_t ctl
);

  localparam int MID_MIN = (SPB * 3) / 4;
  localparam int TIMEOUT = (SPB * 3) / 2;
  localparam int CW      = $clog2(TIMEOUT + 1);
  localparam logic [CW:0]   MID_MIN_X = (CW + 1)'(MID_MIN);
  localparam logic [CW:0]   TIMEOUT_X = (CW + 1)'(TIMEOUT);
  localparam logic [CW-1:0] TIMEOUT_G = CW'(TIMEOUT);

  typedef enum logic {ST_IDLE, ST_RUN} st_t;

  st_t           st;
  logic [CW-1:0] gap;
  logic [CW:0]   gapNext;

  always_comb begin
    gapNext       = {1'b0, gap} + (CW + 1)'(1);
    ctl           = '0;
    ctl.bitVal    = edgeRise;
    if (st == ST_IDLE) begin
      ctl.bitStrobe = edgeSeen;
    end else if (edgeSeen && gapNext >= MID_MIN_X) begin
      ctl.bitStrobe = 1'b1;            // a bit wins over the silence limit
    end else if (gapNext >= TIMEOUT_X) begin
      ctl.wordEnd   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      gap <= '0;
    end else if (ctl.bitStrobe) begin
      st  <= ST_RUN;
      gap <= '0;
    end else if (ctl.wordEnd) begin
      st  <= ST_IDLE;
      gap <= '0;
    end else if (st == ST_RUN) begin
      gap <= gap + CW'(1);
    end
  end

  // R3: the gap timer never passes the silence limit inside a word
  a_r3_gap_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN) |-> (gap < TIMEOUT_G)) else $error("gap counter overran");

  // R6: a silent full window closes the word
  a_r6_timeout_ends: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN && !edgeSeen && gap == TIMEOUT_G - CW'(1)) |=> (st == ST_IDLE))
    else $error("word not closed after silence");

endmodule

// File: rtl/mrx_decoder.sv
module mrx_decoder #(
  parameter int SPB         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineP,
  input  logic lineN,
  input  logic testP,
  input  logic testN,
  input  logic selTest,
  output logic dataOut,
  output logic clkOut,
  output logic envelope,
  output logic pairErr
);

  mrx_pkg::mrx_ctl_t ctl;
  logic edgeSeen;
  logic edgeRise;

  mrx_datapath #(.SPB(SPB), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineP    (lineP),
    .lineN    (lineN),
    .testP    (testP),
    .testN    (testN),
    .selTest  (selTest),
    .ctl      (ctl),
    .edgeSeen (edgeSeen),
    .edgeRise (edgeRise),
    .dataOut  (dataOut),
    .clkOut   (clkOut),
    .envelope (envelope),
    .pairErr  (pairErr)
  );

  mrx_control #(.SPB(SPB)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .edgeSeen (edgeSeen),
    .edgeRise (edgeRise),
    .ctl      (ctl)
  );

endmodule

// File: tb/sim_mrx_decoder.sv
`timescale 1ns/1ps
module sim_mrx_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineP = 1'b0, lineN = 1'b1, testP = 1'b0, testN = 1'b1, selTest = 1'b0;
  logic dataOut, clkOut, envelope, pairErr;

  always #2 clk = ~clk;  // 250 MHz

  mrx_decoder u0 (
    .clk(clk), .rstN(rstN), .lineP(lineP), .lineN(lineN), .testP(testP),
    .testN(testN), .selTest(selTest), .dataOut(dataOut), .clkOut(clkOut),
    .envelope(envelope), .pairErr(pairErr)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  started = 1'b0;
  bit  useTest = 1'b0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  bit hP[1:3];
  bit hN[1:3];
  bit mAct, eData, eClk, eEnv, eErr, mEdge, mStrobe, pinP, pinN;
  int mGap, mAge;

  task automatic modelReset();
    for (int i = 1; i <= 3; i++) begin hP[i] = 1'b0; hN[i] = 1'b1; end
    mAct = 1'b0; mGap = 0; mAge = 1000;
    eData = 1'b0; eClk = 1'b1; eEnv = 1'b0; eErr = 1'b0;
  endtask

  initial modelReset();

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelReset();
    end else begin
      pinP = selTest ? testP : lineP;
      pinN = selTest ? testN : lineN;
      if (mAct) mGap++;
      mEdge   = (hP[2] != hP[3]);
      mStrobe = mEdge && (!mAct || mGap >= 12);
      if (mStrobe) begin
        mAct = 1'b1; mGap = 0; eData = hP[2]; mAge = 0;
      end else begin
        if (mAct && mGap >= 24) begin mAct = 1'b0; mGap = 0; end
        if (mAge < 1000) mAge++;
      end
      eEnv = mAct;
      eClk = (mAge >= 8);
      eErr = (hP[2] == hN[2]);
      hP[3] = hP[2]; hP[2] = hP[1]; hP[1] = pinP;
      hN[3] = hN[2]; hN[2] = hN[1]; hN[1] = pinN;
    end
  end

  // ---------------- per-cycle comparison and monitors ----------------
  bit prevClk = 1'b1, prevEnv = 1'b0;
  bit got[$];
  int envFalls = 0;
  int errHigh = 0;

  always @(negedge clk) begin
    if (started && rstN && !done) begin
      chk(dataOut === eData, "R2", "dataOut vs model", int'(dataOut), int'(eData));
      chk(clkOut === eClk, "R4", "clkOut vs model", int'(clkOut), int'(eClk));
      chk(envelope === eEnv, "R6", "envelope vs model", int'(envelope), int'(eEnv));
      chk(pairErr === eErr, "R8", "pairErr vs model", int'(pairErr), int'(eErr));
      if (clkOut && !prevClk) got.push_back(dataOut);
      if (!envelope && prevEnv) envFalls++;
      if (pairErr) errHigh++;
    end
    prevClk = clkOut;
    prevEnv = envelope;
  end

  // ---------------- stimulus helpers ----------------
  task automatic drv(input logic v, input int n);
    if (useTest) begin testP = v; testN = ~v; end
    else         begin lineP = v; lineN = ~v; end
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // first half at the inverse level, second half at the bit value
  task automatic sendWord(input bit bq[$], input int h1, input int h2);
    foreach (bq[i]) begin
      drv(~bq[i], h1);
      drv(bq[i], h2);
    end
    drv(1'b0, 40);
  endtask

  task automatic checkWord(input bit bq[$], input string req);
    bit same;
    chk(got.size() == bq.size(), "R4", {req, " clock edge count"}, got.size(), bq.size());
    same = (got.size() == bq.size());
    if (same) foreach (bq[i]) if (got[i] != bq[i]) same = 1'b0;
    chk(same, req, "decoded bit sequence", int'(same), 1);
    got.delete();
  endtask

  // two bits of 1 whose mid-bit transitions are 'spacing' clocks apart
  task automatic sendSpaced(input int spacing);
    drv(1'b0, 8); drv(1'b1, 8);
    drv(1'b0, spacing - 8); drv(1'b1, 8);
    drv(1'b0, 40);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  // ---------------- main sequence ----------------
  initial begin
    bit w[$];
    int f0;
    repeat (4) @(posedge clk);
    #1;
    // R10: reset state
    chk(dataOut === 1'b0 && clkOut === 1'b1 && envelope === 1'b0 && pairErr === 1'b0,
        "R10", "outputs during reset", int'({dataOut, clkOut, envelope, pairErr}), 4'b0100);
    rstN = 1'b1;
    started = 1'b1;
    repeat (10) begin @(posedge clk); #1; end

    // R1 R2: short 4-bit word, nominal half bits
    w = {1'b1, 1'b0, 1'b1, 1'b0};
    sendWord(w, 8, 8);
    checkWord(w, "R1");

    // R7: 35-bit word, mid spacing 14
    w.delete();
    for (int i = 0; i < 35; i++) w.push_back(i == 0 ? 1'b1 : 1'((i * 7 + 3) % 5 < 2));
    sendWord(w, 7, 7);
    checkWord(w, "R7");

    // R3: shortest accepted spacing 12, boundary transitions at 6 ignored
    w = {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    sendWord(w, 6, 6);
    checkWord(w, "R3");

    // R3: boundary at 11 ignored, mid spacing 23 keeps the word open
    f0 = envFalls;
    sendWord(w, 12, 11);
    checkWord(w, "R3");
    chk(envFalls - f0 == 1, "R6", "one envelope close for spacing 23", envFalls - f0, 1);

    // R7: single-bit word and a 300-bit word
    w = {1'b1};
    sendWord(w, 8, 8);
    checkWord(w, "R7");
    w.delete();
    for (int i = 0; i < 300; i++) w.push_back(i == 0 ? 1'b1 : 1'((i * 13 + 5) % 7 < 3));
    sendWord(w, 8, 8);
    checkWord(w, "R7");

    // R6: transition exactly at the silence limit is a bit
    f0 = envFalls;
    sendSpaced(24);
    w = {1'b1, 1'b1};
    checkWord(w, "R6");
    chk(envFalls - f0 == 1, "R6", "spacing 24 stays one word", envFalls - f0, 1);
    // R6: one clock later the word closes and a new one opens
    f0 = envFalls;
    sendSpaced(25);
    checkWord(w, "R6");
    chk(envFalls - f0 == 2, "R6", "spacing 25 splits into two words", envFalls - f0, 2);

    // R8: equal levels on the selected pair
    lineN = 1'b0;
    repeat (4) begin @(posedge clk); #1; end
    chk(pairErr === 1'b1, "R8", "pairErr on equal lines", int'(pairErr), 1);
    chk(envelope === 1'b0, "R8", "no word from complement fault", int'(envelope), 0);
    lineN = 1'b1;
    repeat (4) begin @(posedge clk); #1; end
    chk(pairErr === 1'b0, "R8", "pairErr cleared", int'(pairErr), 0);

    // R9: self-test pair selected, receive pair disturbed and ignored
    selTest = 1'b1;
    repeat (4) begin @(posedge clk); #1; end
    lineP = 1'b1; lineN = 1'b1;
    errHigh = 0;
    useTest = 1'b1;
    w = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    sendWord(w, 8, 8);
    checkWord(w, "R9");
    chk(errHigh == 0, "R9", "receive pair fault ignored", errHigh, 0);
    // R9: back to the receive pair, self-test pair disturbed
    lineP = 1'b0; lineN = 1'b1;
    repeat (2) begin @(posedge clk); #1; end
    selTest = 1'b0;
    repeat (4) begin @(posedge clk); #1; end
    useTest = 1'b0;
    testP = 1'b1; testN = 1'b1;
    errHigh = 0;
    sendWord(w, 8, 8);
    checkWord(w, "R9");
    chk(errHigh == 0, "R9", "self-test pair fault ignored", errHigh, 0);
    testP = 1'b0; testN = 1'b1;

    // R10: reset in the middle of a word
    drv(1'b0, 8); drv(1'b1, 8); drv(1'b1, 8); drv(1'b0, 4);
    chk(envelope === 1'b1, "R10", "word open before reset", int'(envelope), 1);
    rstN = 1'b0;
    #0.5;
    chk(dataOut === 1'b0 && clkOut === 1'b1 && envelope === 1'b0 && pairErr === 1'b0,
        "R10", "outputs forced by reset", int'({dataOut, clkOut, envelope, pairErr}), 4'b0100);
    repeat (3) begin @(posedge clk); #1; end
    rstN = 1'b1;
    repeat (40) begin @(posedge clk); #1; end
    chk(envelope === 1'b0 && clkOut === 1'b1, "R10", "idle after reset release",
        int'({envelope, clkOut}), 2'b01);
    got.delete();
    w = {1'b1, 1'b1, 1'b0};
    sendWord(w, 8, 8);
    checkWord(w, "R2");

    done = 1'b1;
    finishRun();
  end

endmodule